// File: doc/BRIEF.md
# Parallel NOR Flash Erase Sequencer

This block takes one erase request at a time from a host and carries it out on an asynchronous parallel NOR flash bus. The bus has an address, a bidirectional byte-wide data path, and active-low chip enable, output enable and write enable strobes. A request selects one of two modes. Whole-device mode erases the entire flash. Sector mode erases one sector, named by the address given with the request.

The block first issues the six-write unlock and erase command sequence. It then polls the device with pairs of reads and watches the toggle bit (data bit 6) until the erase settles. Data bit 5 is the device's own timeout flag. When the device raises it, the block makes one final pair of reads before it decides.

The result is a one-byte status, 0x00 for success and 0xFF for failure. The status is reported together with a single-cycle completion pulse. An optional cycle-count limit on polling ends an erase that never settles.

Top module: `nor_erase_seq`

## Requirements
- R1: The first five bus writes of every request are, in order: 0xAA at address 0x5555, 0x55 at 0x2AAA, 0x80 at 0x5555, 0xAA at 0x5555 and 0x55 at 0x2AAA.
- R2: In whole-device mode (`sector_mode_i`=0) the sixth write is 0x10 at address 0x5555.
- R3: In sector mode (`sector_mode_i`=1) the sixth write is 0x30 at the sector address captured at start.
- R4: All polling reads go to address 0x5555 in whole-device mode and to the captured sector address in sector mode.
- R5: When data bit 6 is equal in both reads of a polling pair, the block reports status 0x00 and makes no further reads. The other data bits, bit 5 included, have no effect in that case.
- R6: When bit 6 differs within a pair and bit 5 of the second read is 0, the block starts a fresh pair of reads.
- R7: When bit 6 differs within a pair and bit 5 of the second read is 1, the block makes exactly one more pair of reads. It reports 0x00 if bit 6 is equal in that pair and 0xFF if it is not.
- R8: Each write holds chip enable and write enable low for WR_CYC clock cycles with output enable high. The data bus is driven only for the duration of a write and stays stable through the rising edge of write enable. Output enable and write enable are never low at the same time.
- R9: Each read holds chip enable and output enable low for RD_CYC clock cycles. Successive reads are separated by at least one cycle with output enable high.
- R10: A start request arriving while the block is busy is ignored. It changes neither the bus traffic nor the mode of the erase in progress, and it does not queue a second erase.
- R11: `done_o` is high for exactly one cycle per request, in the same cycle the new status first appears. `status_o` changes only in a cycle where `done_o` is high and holds its value afterwards.
- R12: With the limit enabled, if polling has lasted WDOG_LIM cycles when a pair ends with bit 6 differing and bit 5 at 0, the block reports 0xFF.
- R13: Out of reset the strobes are high, the data bus is not driven, `busy_o` and `done_o` are low, and `status_o` is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request an erase (accepted only when idle) |
| sector_mode_i | input | 1 | 0 = whole device, 1 = single sector |
| sector_addr_i | input | ADDR_W | Sector address for sector mode |
| busy_o | output | 1 | A request is in progress |
| done_o | output | 1 | One-cycle completion pulse |
| status_o | output | 8 | 0x00 success, 0xFF failure |
| fl_addr_o | output | ADDR_W | Flash address bus |
| fl_data_io | inout | 8 | Flash data bus |
| fl_ce_n_o | output | 1 | Flash chip enable, active low |
| fl_oe_n_o | output | 1 | Flash output enable, active low |
| fl_we_n_o | output | 1 | Flash write enable, active low |

## Verification
The bench builds the block with a 16-bit address, WR_CYC=3, RD_CYC=2 and the polling limit enabled at WDOG_LIM=50. Because the write and read pulse lengths differ, a swap of the two timing counts shows up in the measured strobe widths. The small limit lets a device that toggles forever hit the limit after a handful of polling pairs. Scripted flash responses drive every polling outcome: immediate settle, several fresh pairs, recheck success, recheck failure, and a settle where only unrelated bits toggle.

// File: rtl/nor_erase_pkg.sv
package nor_erase_pkg;
  localparam logic [7:0] ST_PASS = 8'h00;
  localparam logic [7:0] ST_FAIL = 8'hFF;

  localparam logic [15:0] ADR_KEY_A = 16'h5555;
  localparam logic [15:0] ADR_KEY_B = 16'h2AAA;

  localparam logic [7:0] DAT_KEY_A   = 8'hAA;
  localparam logic [7:0] DAT_KEY_B   = 8'h55;
  localparam logic [7:0] DAT_SETUP   = 8'h80;
  localparam logic [7:0] DAT_ALL_GO  = 8'h10;
  localparam logic [7:0] DAT_SECT_GO = 8'h30;

  localparam int TOGGLE_BIT = 6;
  localparam int DEVTMO_BIT = 5;
  localparam int CMD_STEPS  = 6;

  typedef enum logic [2:0] {
    SQ_IDLE, SQ_CMD, SQ_POLL_A, SQ_POLL_B, SQ_RCHK_A, SQ_RCHK_B, SQ_DONE
  } sq_state_t;

  typedef enum logic [1:0] {
    BC_IDLE, BC_ACT, BC_REC
  } bc_state_t;
endpackage

// File: rtl/nor_cmd_table.sv
module nor_cmd_table
  import nor_erase_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic [2:0]        step_i,
  input  logic              sector_mode_i,
  input  logic [ADDR_W-1:0] sector_addr_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [7:0]        data_o
);
  localparam logic [ADDR_W-1:0] KA = ADDR_W'(ADR_KEY_A);
  localparam logic [ADDR_W-1:0] KB = ADDR_W'(ADR_KEY_B);

  always_comb begin
    addr_o = KA;
    data_o = DAT_KEY_A;
    case (step_i)
      3'd0: begin addr_o = KA; data_o = DAT_KEY_A; end
      3'd1: begin addr_o = KB; data_o = DAT_KEY_B; end
      3'd2: begin addr_o = KA; data_o = DAT_SETUP; end
      3'd3: begin addr_o = KA; data_o = DAT_KEY_A; end
      3'd4: begin addr_o = KB; data_o = DAT_KEY_B; end
      3'd5: begin
        if (sector_mode_i) begin
          addr_o = sector_addr_i;
          data_o = DAT_SECT_GO;
        end else begin
          addr_o = KA;
          data_o = DAT_ALL_GO;
        end
      end
      default: begin addr_o = KA; data_o = DAT_KEY_A; end
    endcase
  end
endmodule

// File: rtl/nor_bus_cycle.sv
module nor_bus_cycle
  import nor_erase_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int WR_CYC = 3,
  parameter int RD_CYC = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  output logic              ack_o,
  output logic [7:0]        rdata_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic [7:0]        bus_wdata_o,
  output logic              bus_drv_o,
  input  logic [7:0]        bus_rdata_i,
  output logic              ce_n_o,
  output logic              oe_n_o,
  output logic              we_n_o
);
  localparam int ACT_MAX = (WR_CYC > RD_CYC) ? WR_CYC : RD_CYC;
  localparam int CNT_W   = (ACT_MAX > 1) ? $clog2(ACT_MAX) : 1;
  localparam logic [CNT_W-1:0] WR_LAST = CNT_W'(WR_CYC - 1);
  localparam logic [CNT_W-1:0] RD_LAST = CNT_W'(RD_CYC - 1);

  bc_state_t         st_q, st_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              wr_q;
  logic [ADDR_W-1:0] addr_q;
  logic [7:0]        wdata_q, rdata_q;
  logic              load_en, cap_en;
  logic [CNT_W-1:0]  last;

  assign last = wr_q ? WR_LAST : RD_LAST;

  always_comb begin
    st_d    = st_q;
    cnt_d   = cnt_q;
    load_en = 1'b0;
    cap_en  = 1'b0;
    case (st_q)
      BC_IDLE: if (req_i) begin
        st_d    = BC_ACT;
        cnt_d   = '0;
        load_en = 1'b1;
      end
      BC_ACT: if (cnt_q == last) begin
        st_d   = BC_REC;
        cap_en = !wr_q;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
      BC_REC:  st_d = BC_IDLE;
      default: st_d = BC_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= BC_IDLE;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (load_en) begin
      wr_q    <= wr_i;
      addr_q  <= addr_i;
      wdata_q <= wdata_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rdata_q <= '0;
    else if (cap_en) rdata_q <= bus_rdata_i;
  end

  assign ack_o       = (st_q == BC_REC);
  assign rdata_o     = rdata_q;
  assign bus_addr_o  = addr_q;
  assign bus_wdata_o = wdata_q;
  assign bus_drv_o   = wr_q && (st_q != BC_IDLE);
  assign ce_n_o      = (st_q != BC_ACT);
  assign we_n_o      = !((st_q == BC_ACT) && wr_q);
  assign oe_n_o      = !((st_q == BC_ACT) && !wr_q);
endmodule

// File: rtl/nor_poll_limit.sv
module nor_poll_limit #(
  parameter bit EN  = 1'b1,
  parameter int LIM = 4096
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear_i,
  input  logic run_i,
  output logic expired_o
);
  localparam int CW = $clog2(LIM + 1);

  generate
    if (EN) begin : g_on
      logic [CW-1:0] cnt_q, cnt_d;
      always_comb begin
        cnt_d = cnt_q;
        if (clear_i)                          cnt_d = '0;
        else if (run_i && cnt_q != CW'(LIM)) cnt_d = cnt_q + 1'b1;
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
      end
      assign expired_o = (cnt_q == CW'(LIM));
    end else begin : g_off
      assign expired_o = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/nor_erase_seq.sv
module nor_erase_seq
  import nor_erase_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int WR_CYC   = 3,
  parameter int RD_CYC   = 2,
  parameter bit WDOG_EN  = 1'b1,
  parameter int WDOG_LIM = 4096
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              sector_mode_i,
  input  logic [ADDR_W-1:0] sector_addr_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [7:0]        status_o,
  output logic [ADDR_W-1:0] fl_addr_o,
  inout  wire  [7:0]        fl_data_io,
  output logic              fl_ce_n_o,
  output logic              fl_oe_n_o,
  output logic              fl_we_n_o
);
  localparam logic [2:0] LAST_STEP = 3'(CMD_STEPS - 1);

  logic [1:0] rst_pipe;
  logic       rst_n_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_n_s = rst_pipe[1];

  sq_state_t         sq_q, sq_d;
  logic [2:0]        step_q, step_d;
  logic              mode_q;
  logic [ADDR_W-1:0] saddr_q;
  logic [7:0]        first_q, first_d;
  logic [7:0]        status_q, status_d;
  logic              accept, status_en;

  logic              bc_req, bc_wr, bc_ack, dbus_drv;
  logic [ADDR_W-1:0] bc_addr, cmd_addr, poll_addr;
  logic [7:0]        bc_wdata, cmd_data, bc_rdata, bus_wdata;
  logic              lim_hit, polling, settled;

  nor_cmd_table #(.ADDR_W(ADDR_W)) u_cmd (
    .step_i       (step_q),
    .sector_mode_i(mode_q),
    .sector_addr_i(saddr_q),
    .addr_o       (cmd_addr),
    .data_o       (cmd_data)
  );

  nor_bus_cycle #(.ADDR_W(ADDR_W), .WR_CYC(WR_CYC), .RD_CYC(RD_CYC)) u_bus (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .req_i      (bc_req),
    .wr_i       (bc_wr),
    .addr_i     (bc_addr),
    .wdata_i    (bc_wdata),
    .ack_o      (bc_ack),
    .rdata_o    (bc_rdata),
    .bus_addr_o (fl_addr_o),
    .bus_wdata_o(bus_wdata),
    .bus_drv_o  (dbus_drv),
    .bus_rdata_i(fl_data_io),
    .ce_n_o     (fl_ce_n_o),
    .oe_n_o     (fl_oe_n_o),
    .we_n_o     (fl_we_n_o)
  );

  assign fl_data_io = dbus_drv ? bus_wdata : 8'hzz;

  assign polling = (sq_q == SQ_POLL_A) || (sq_q == SQ_POLL_B);
  assign accept  = (sq_q == SQ_IDLE) && start_i;

  nor_poll_limit #(.EN(WDOG_EN), .LIM(WDOG_LIM)) u_lim (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .clear_i  (accept),
    .run_i    (polling),
    .expired_o(lim_hit)
  );

  assign poll_addr = mode_q ? saddr_q : ADDR_W'(ADR_KEY_A);
  assign settled   = (first_q[TOGGLE_BIT] == bc_rdata[TOGGLE_BIT]);

  always_comb begin
    sq_d      = sq_q;
    step_d    = step_q;
    first_d   = first_q;
    status_d  = status_q;
    status_en = 1'b0;
    bc_req    = 1'b0;
    bc_wr     = 1'b0;
    bc_addr   = poll_addr;
    bc_wdata  = cmd_data;
    case (sq_q)
      SQ_IDLE: if (start_i) begin
        sq_d   = SQ_CMD;
        step_d = '0;
      end
      SQ_CMD: begin
        bc_req  = 1'b1;
        bc_wr   = 1'b1;
        bc_addr = cmd_addr;
        if (bc_ack) begin
          if (step_q == LAST_STEP) sq_d = SQ_POLL_A;
          else                     step_d = step_q + 1'b1;
        end
      end
      SQ_POLL_A, SQ_RCHK_A: begin
        bc_req = 1'b1;
        if (bc_ack) begin
          first_d = bc_rdata;
          sq_d    = (sq_q == SQ_POLL_A) ? SQ_POLL_B : SQ_RCHK_B;
        end
      end
      SQ_POLL_B: begin
        bc_req = 1'b1;
        if (bc_ack) begin
          if (settled) begin
            sq_d = SQ_DONE; status_d = ST_PASS; status_en = 1'b1;
          end else if (bc_rdata[DEVTMO_BIT]) begin
            sq_d = SQ_RCHK_A;
          end else if (lim_hit) begin
            sq_d = SQ_DONE; status_d = ST_FAIL; status_en = 1'b1;
          end else begin
            sq_d = SQ_POLL_A;
          end
        end
      end
      SQ_RCHK_B: begin
        bc_req = 1'b1;
        if (bc_ack) begin
          sq_d      = SQ_DONE;
          status_d  = settled ? ST_PASS : ST_FAIL;
          status_en = 1'b1;
        end
      end
      SQ_DONE: sq_d = SQ_IDLE;
      default: sq_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      sq_q    <= SQ_IDLE;
      step_q  <= '0;
      first_q <= '0;
    end else begin
      sq_q    <= sq_d;
      step_q  <= step_d;
      first_q <= first_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      mode_q  <= 1'b0;
      saddr_q <= '0;
    end else if (accept) begin
      mode_q  <= sector_mode_i;
      saddr_q <= sector_addr_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s)       status_q <= ST_PASS;
    else if (status_en) status_q <= status_d;
  end

  assign busy_o   = (sq_q != SQ_IDLE);
  assign done_o   = (sq_q == SQ_DONE);
  assign status_o = status_q;
endmodule

// File: rtl/nor_erase_chk.sv
module nor_erase_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start_i,
  input logic       busy_o,
  input logic       done_o,
  input logic [7:0] status_o,
  input logic       ce_n,
  input logic       oe_n,
  input logic       we_n,
  input logic       drv,
  input logic       mode_q
);
  p_strobe_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(!oe_n && !we_n));

  p_drive_oe_high_r8: assert property (@(posedge clk) disable iff (!rst_n)
    drv |-> oe_n);

  p_read_needs_ce_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!oe_n || !we_n) |-> !ce_n);

  p_done_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  p_status_moves_on_done_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (status_o != $past(status_o)) |-> done_o);

  p_status_code_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (status_o == 8'h00 || status_o == 8'hFF));

  p_start_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i) |=> $stable(mode_q));

  p_idle_quiet_r13: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (ce_n && !drv));
endmodule

bind nor_erase_seq nor_erase_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n_s),
  .start_i (start_i),
  .busy_o  (busy_o),
  .done_o  (done_o),
  .status_o(status_o),
  .ce_n    (fl_ce_n_o),
  .oe_n    (fl_oe_n_o),
  .we_n    (fl_we_n_o),
  .drv     (dbus_drv),
  .mode_q  (mode_q)
);

// File: tb/test_nor_erase_seq.sv
`timescale 1ns/1ps
module test_nor_erase_seq;
  localparam int AW    = 16;
  localparam int WRC   = 3;
  localparam int RDC   = 2;
  localparam int LIMIT = 50;
  localparam int NVEC  = 7;

  // vector: [28] mode, [27:12] sector address, [11:8] scenario, [7:0] expected status
  localparam logic [31:0] VEC [NVEC] = '{
    {3'b0, 1'b0, 16'h0000, 4'd0, 8'h00},
    {3'b0, 1'b1, 16'h4000, 4'd0, 8'h00},
    {3'b0, 1'b0, 16'h0000, 4'd1, 8'h00},
    {3'b0, 1'b1, 16'h1000, 4'd2, 8'h00},
    {3'b0, 1'b1, 16'hC000, 4'd3, 8'hFF},
    {3'b0, 1'b0, 16'h0000, 4'd5, 8'h00},
    {3'b0, 1'b0, 16'h0000, 4'd4, 8'hFF}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic smode = 1'b0;
  logic [AW-1:0] saddr = '0;
  logic busy, done, ce_n, oe_n, we_n;
  logic [7:0] status;
  logic [AW-1:0] faddr;
  wire  [7:0] fdata;

  int total = 0;
  int fails = 0;

  always #5 clk = ~clk;

  nor_erase_seq #(.ADDR_W(AW), .WR_CYC(WRC), .RD_CYC(RDC),
                  .WDOG_EN(1'b1), .WDOG_LIM(LIMIT)) i_nor_erase_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start), .sector_mode_i(smode),
    .sector_addr_i(saddr), .busy_o(busy), .done_o(done), .status_o(status),
    .fl_addr_o(faddr), .fl_data_io(fdata), .fl_ce_n_o(ce_n),
    .fl_oe_n_o(oe_n), .fl_we_n_o(we_n)
  );

  // flash responder
  int       scen = 0;
  int       rd_cnt = 0;
  int       wr_cnt = 0;
  bit       armed = 1'b0;
  logic [AW-1:0] exp_paddr = '0;
  logic [AW-1:0] wr_a [8];
  logic [7:0]    wr_d [8];
  int       rd_addr_bad = 0, wr_w_bad = 0, rd_w_bad = 0, gap_bad = 0;
  longint   t_wf = 0, t_of = 0, t_or = 0;

  function automatic logic [7:0] scen_byte(int s, int n);
    logic b6, b5;
    case (s)
      0: return 8'h80;
      1: return (n < 6) ? {1'b0, n[0], 6'b0} : 8'h40;
      2: begin b6 = (n < 4) ? n[0] : 1'b0; b5 = (n >= 3); return {1'b0, b6, b5, 5'b0}; end
      3: begin b5 = (n >= 1); return {1'b0, n[0], b5, 5'b0}; end
      4: return {1'b0, n[0], 6'b0};
      default: return {3'b011, 2'b00, n[0], 2'b00};
    endcase
  endfunction

  function automatic int exp_reads(int s);
    case (s)
      0: return 2;
      1: return 8;
      2: return 6;
      3: return 4;
      5: return 2;
      default: return -1;
    endcase
  endfunction

  assign fdata = (!ce_n && !oe_n) ? scen_byte(scen, rd_cnt - 1) : 8'hzz;

  always @(negedge we_n) t_wf = $time;
  always @(posedge we_n) if (armed) begin
    if ($time - t_wf != WRC * 10) wr_w_bad++;
    if (wr_cnt < 8) begin
      wr_a[wr_cnt] = faddr;
      wr_d[wr_cnt] = fdata;
    end
    wr_cnt++;
  end
  always @(negedge oe_n) if (armed) begin
    if (rd_cnt > 0 && ($time - t_or) < 10) gap_bad++;
    if (faddr != exp_paddr) rd_addr_bad++;
    t_of = $time;
    rd_cnt++;
  end
  always @(posedge oe_n) if (armed) begin
    if ($time - t_of != RDC * 10) rd_w_bad++;
    t_or = $time;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  endtask

  function automatic logic [AW-1:0] exp_wa(int i, bit m, logic [AW-1:0] sa);
    case (i)
      1, 4: return AW'(16'h2AAA);
      5: return m ? sa : AW'(16'h5555);
      default: return AW'(16'h5555);
    endcase
  endfunction

  function automatic logic [7:0] exp_wd(int i, bit m);
    case (i)
      0, 3: return 8'hAA;
      1, 4: return 8'h55;
      2: return 8'h80;
      default: return m ? 8'h30 : 8'h10;
    endcase
  endfunction

  int done_cyc = 0;
  logic [7:0] st_at_done = '0;

  task automatic run_op(input bit m, input logic [AW-1:0] sa, input int s,
                        input bit poke_busy);
    scen = s;
    rd_cnt = 0; wr_cnt = 0; rd_addr_bad = 0; wr_w_bad = 0; rd_w_bad = 0; gap_bad = 0;
    exp_paddr = m ? sa : AW'(16'h5555);
    done_cyc = 0;
    armed = 1'b1;
    @(negedge clk);
    start = 1'b1; smode = m; saddr = sa;
    @(negedge clk);
    start = 1'b0;
    for (int c = 0; c < 5000; c++) begin
      @(negedge clk);
      if (poke_busy && c == 10) begin start = 1'b1; smode = ~m; saddr = 16'hBEEF; end
      if (poke_busy && c == 11) start = 1'b0;
      if (done) begin done_cyc++; st_at_done = status; end
      if (!busy && done_cyc > 0) break;
    end
    armed = 1'b0;
  endtask

  task automatic check_op(input bit m, input logic [AW-1:0] sa, input int s,
                          input logic [7:0] est);
    chk(wr_cnt == 6, "R1", "write count", wr_cnt, 6);
    for (int i = 0; i < 5; i++) begin
      chk(wr_a[i] == exp_wa(i, m, sa), "R1", "cmd addr", wr_a[i], exp_wa(i, m, sa));
      chk(wr_d[i] == exp_wd(i, m), "R1", "cmd data", wr_d[i], exp_wd(i, m));
    end
    chk(wr_a[5] == exp_wa(5, m, sa), m ? "R3" : "R2", "final addr", wr_a[5], exp_wa(5, m, sa));
    chk(wr_d[5] == exp_wd(5, m), m ? "R3" : "R2", "final data", wr_d[5], exp_wd(5, m));
    chk(rd_addr_bad == 0, "R4", "poll address misses", rd_addr_bad, 0);
    if (exp_reads(s) >= 0)
      chk(rd_cnt == exp_reads(s), s == 1 ? "R6" : (s >= 2 && s <= 3 ? "R7" : "R5"),
          "read count", rd_cnt, exp_reads(s));
    chk(st_at_done == est, s == 4 ? "R12" : (s == 2 || s == 3 ? "R7" : "R5"),
        "status", st_at_done, est);
    chk(done_cyc == 1, "R11", "done cycles", done_cyc, 1);
    chk(wr_w_bad == 0, "R8", "write pulse width errors", wr_w_bad, 0);
    chk(rd_w_bad == 0, "R9", "read pulse width errors", rd_w_bad, 0);
    chk(gap_bad == 0, "R9", "read gap errors", gap_bad, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog: actual running expected finished");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R13 reset state
    chk(ce_n && oe_n && we_n, "R13", "strobes", {ce_n, oe_n, we_n}, 3'b111);
    chk(!busy, "R13", "busy", busy, 0);
    chk(!done, "R13", "done", done, 0);
    chk(status == 8'h00, "R13", "status", status, 0);

    for (int v = 0; v < NVEC; v++) begin
      run_op(VEC[v][28], VEC[v][27:12], int'(VEC[v][11:8]), 1'b0);
      check_op(VEC[v][28], VEC[v][27:12], int'(VEC[v][11:8]), VEC[v][7:0]);
      repeat (3) @(negedge clk);
    end

    // R11: status held after completion
    repeat (10) @(negedge clk);
    chk(status == 8'hFF, "R11", "status held", status, 8'hFF);

    // R10: start while busy ignored
    run_op(1'b0, 16'h0000, 0, 1'b1);
    check_op(1'b0, 16'h0000, 0, 8'h00);
    repeat (20) @(negedge clk);
    chk(!busy, "R10", "no queued request", busy, 0);
    chk(status == 8'h00, "R10", "status after ignored start", status, 0);
    summary();
  end
endmodule